// File: doc/BRIEF.md
# Gated Parallel FIFO Write Engine

This block pushes a stream of bytes into an external parallel FIFO device over an 8-bit bus. Each byte takes a fixed period of 16 clock cycles. Inside each period a cycle counter decides when the next byte is taken from the source, and when the active-low write strobe falls to commit that byte. The device's active-low space flag gates the counter. While the flag is high the counter freezes at its current value, in the middle of the period, and it carries on from the same value once the flag returns low.

A start command carries a 16-bit byte count. The engine cuts that count into bursts of at most 256 bytes, and the last burst takes the remainder. Between bursts the engine pauses for one cycle to pick the next burst size. When nothing is left it pulses `done_o` and returns to idle. Bytes come from a ready/valid source. The engine does not leave reset ready for commands: it first waits for the device's active-low receive-ready flag to go low. The device read strobe is never used and stays inactive.

Top module: `gated_fifo_writer`

## Requirements
- R1: After reset `wr_n_o` is 1, `busy_o` is 0 and `done_o` is 0.
- R2: With `space_n_i` low and the source always valid, a byte period lasts 16 cycles. `wr_n_o` is high during counts 0 to 8 and low during counts 9 to 15, which gives 7 low cycles per byte. `data_o` is loaded at count 1 and does not change while `wr_n_o` is low.
- R3: Bytes appear on `data_o` in source order, exactly once each, and each is present at the falling edge of `wr_n_o`.
- R4: While `space_n_i` is high, the period counter, `wr_n_o` and `data_o` all hold. When the flag drops, the period resumes from the count at which it stopped.
- R5: A length L is sent as bursts of min(remaining, 256) bytes with one idle cycle after each burst. `busy_o` is therefore high for the sum over bursts of (16·b + 1) cycles; for example, 520 gives bursts of 256, 256 and 8, which is 8323 cycles.
- R6: After the last burst, `done_o` is high for exactly one cycle, which is the final cycle in which `busy_o` is high. The engine then goes idle with `wr_n_o` high.
- R7: A start with length 0 is rejected. `err_o` pulses for one cycle, and `busy_o` stays low.
- R8: After reset, start commands are ignored until `rxrdy_n_i` has been seen low.
- R9: `rd_n_o` is 1 at all times.
- R10: If `src_valid_i` is low when the count reaches 1, the counter holds at count 1 with `wr_n_o` high and `src_ready_o` high until a byte arrives.
- R11: A start command that arrives while `busy_o` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start command, one cycle |
| len_i | input | 16 | Byte count taken with start |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle zero-length rejection pulse |
| src_data_i | input | 8 | Source byte |
| src_valid_i | input | 1 | Source byte valid |
| src_ready_o | output | 1 | Engine takes the byte this cycle if valid |
| space_n_i | input | 1 | Device space available, active low |
| rxrdy_n_i | input | 1 | Device receive-ready, active low |
| data_o | output | 8 | Parallel data bus to device |
| wr_n_o | output | 1 | Write strobe, active low |
| rd_n_o | output | 1 | Read strobe, held inactive high |

## Verification
The hardest situation to reach is a freeze that lands exactly inside the strobe-low window. In that case the engine must hold the strobe low and resume from count 9 rather than from the start of the period. The bench waits for the falling strobe edge, raises the space flag at that moment, holds it for 20 cycles, and then drops it. It then counts that exactly six more low cycles follow before the done pulse arrives. A second hard case is a source that stalls at count 1. The bench forces valid low before the start command, which parks the counter at count 1, and then confirms that no strobe edge and no duplicated byte appear.

// File: rtl/gated_fifo_writer.sv
module gated_fifo_writer #(
  parameter int DW        = 8,
  parameter int LW        = 16,
  parameter int PERIOD    = 16,
  parameter int DATA_AT   = 1,
  parameter int STROBE_AT = 9,
  parameter int BURST_MAX = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  input  logic [DW-1:0] src_data_i,
  input  logic          src_valid_i,
  output logic          src_ready_o,
  input  logic          space_n_i,
  input  logic          rxrdy_n_i,
  output logic [DW-1:0] data_o,
  output logic          wr_n_o,
  output logic          rd_n_o
);
  localparam int CW = $clog2(PERIOD);
  localparam int BW = $clog2(BURST_MAX + 1);
  localparam logic [LW:0]   BMAX    = (LW+1)'(BURST_MAX);
  localparam logic [CW-1:0] C_DATA  = CW'(DATA_AT);
  localparam logic [CW-1:0] C_STRB  = CW'(STROBE_AT);
  localparam logic [CW-1:0] C_LAST  = CW'(PERIOD - 1);

  typedef enum logic [1:0] {S_WAIT, S_IDLE, S_RUN, S_GAP} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] burst_left;
  logic [LW-1:0] remain;
  logic [DW-1:0] data_q;
  logic          err_q;

  logic          run, at_data, step, take, accept;
  logic [LW-1:0] seg_src, seg_rest;
  logic [BW-1:0] seg_len;
  logic          big;

  assign run     = (st == S_RUN);
  assign at_data = run && (cnt == C_DATA);
  assign step    = run && !space_n_i && (cnt != C_DATA || src_valid_i);
  assign take    = at_data && !space_n_i && src_valid_i;
  assign accept  = (st == S_IDLE) && start_i && (len_i != '0);

  assign seg_src  = (st == S_IDLE) ? len_i : remain;
  assign big      = {1'b0, seg_src} > BMAX;
  assign seg_len  = big ? BW'(BURST_MAX) : seg_src[BW-1:0];
  assign seg_rest = big ? seg_src - LW'(BURST_MAX) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_WAIT;
      cnt        <= '0;
      burst_left <= '0;
      remain     <= '0;
      data_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      err_q <= (st == S_IDLE) && start_i && (len_i == '0);
      case (st)
        S_WAIT: if (!rxrdy_n_i) st <= S_IDLE;
        S_IDLE: if (accept) begin
          burst_left <= seg_len;
          remain     <= seg_rest;
          cnt        <= '0;
          st         <= S_RUN;
        end
        S_RUN: begin
          if (take) data_q <= src_data_i;
          if (step) begin
            if (cnt == C_LAST) begin
              cnt        <= '0;
              burst_left <= burst_left - 1'b1;
              if (burst_left == BW'(1)) st <= S_GAP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (remain == '0) begin
            st <= S_IDLE;
          end else begin
            burst_left <= seg_len;
            remain     <= seg_rest;
            cnt        <= '0;
            st         <= S_RUN;
          end
        end
      endcase
    end
  end

  assign busy_o      = run || (st == S_GAP);
  assign done_o      = (st == S_GAP) && (remain == '0);
  assign err_o       = err_q;
  assign src_ready_o = at_data && !space_n_i;
  assign data_o      = data_q;
  assign wr_n_o      = !(run && cnt >= C_STRB);
  assign rd_n_o      = 1'b1;
endmodule

// File: rtl/gated_fifo_writer_chk.sv
module gated_fifo_writer_chk #(
  parameter int DW = 8,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [LW-1:0] len_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          src_ready_o,
  input logic          space_n_i,
  input logic [DW-1:0] data_o,
  input logic          wr_n_o,
  input logic          rd_n_o
);
  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n_o && !$past(wr_n_o)) |-> $stable(data_o));
  // R1
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> wr_n_o);
  // R9
  rd_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n_o);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o && wr_n_o);
  // R4
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && space_n_i && !done_o) |=> $stable(wr_n_o) && $stable(data_o));
  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(start_i) && ($past(len_i) == '0) && !busy_o);
  // R10
  ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready_o |-> wr_n_o && busy_o);
endmodule

bind gated_fifo_writer gated_fifo_writer_chk #(.DW(DW), .LW(LW)) i_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .src_ready_o(src_ready_o), .space_n_i(space_n_i), .data_o(data_o),
  .wr_n_o(wr_n_o), .rd_n_o(rd_n_o)
);

// File: tb/test_gated_fifo_writer.sv
module test_gated_fifo_writer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [15:0] len_i = '0;
  logic busy_o, done_o, err_o, src_ready_o, wr_n_o, rd_n_o;
  logic [7:0] data_o, src_data_i;
  logic src_valid_i, space_n_i;
  logic rxrdy_n_i = 1'b1;

  int tick = 0, src_idx = 0;
  int space_mode = 0, valid_mode = 0;
  logic space_force = 1'b0, valid_hold = 1'b0;
  int checks = 0, errors = 0, cyc = 0;
  int rx_count = 0, rx_total = 0, done_cnt = 0, err_cnt = 0, busy_cyc = 0, low_cyc = 0;
  logic prev_wr = 1'b1;

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  assign src_data_i  = pat(src_idx);
  assign src_valid_i = !valid_hold && !(valid_mode != 0 && (tick % 11) < 4);
  assign space_n_i   = space_force || (space_mode != 0 && (tick % 23) < 5);

  gated_fifo_writer i_gated_fifo_writer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .src_data_i(src_data_i), .src_valid_i(src_valid_i), .src_ready_o(src_ready_o),
    .space_n_i(space_n_i), .rxrdy_n_i(rxrdy_n_i),
    .data_o(data_o), .wr_n_o(wr_n_o), .rd_n_o(rd_n_o)
  );

  always @(posedge clk) begin
    tick <= tick + 1;
    if (src_ready_o && src_valid_i) src_idx <= src_idx + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy_o) busy_cyc++;
      if (!wr_n_o) low_cyc++;
      if (done_o) done_cnt++;
      if (err_o) err_cnt++;
      if (prev_wr && !wr_n_o) begin
        // R3: byte at the strobe edge follows source order
        chk(data_o == pat(rx_total), "R3 data", data_o, pat(rx_total));
        rx_total++;
        rx_count++;
      end
      prev_wr = wr_n_o;
    end
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic clr();
    rx_count = 0; done_cnt = 0; err_cnt = 0; busy_cyc = 0; low_cyc = 0;
  endtask

  task automatic go(input int len);
    @(posedge clk); #1;
    start_i = 1'b1; len_i = 16'(len);
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (done_cnt == 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // len, space stall mode, valid stall mode, expected busy cycles (0 = not checked)
  localparam int NV = 7;
  localparam int VEC [0:NV-1][0:3] = '{
    '{1,   0, 0, 17},
    '{3,   0, 0, 49},
    '{256, 0, 0, 4097},
    '{257, 0, 0, 4114},
    '{520, 0, 0, 8323},
    '{40,  1, 1, 0},
    '{300, 1, 0, 0}
  };

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(wr_n_o == 1'b1, "R1 wr_n", wr_n_o, 1);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 busy/done", {busy_o, done_o}, 0);
    // R9
    chk(rd_n_o == 1'b1, "R9 rd_n", rd_n_o, 1);

    // R8: start before receive-ready is ignored
    clr();
    go(1);
    repeat (40) @(negedge clk);
    chk(busy_cyc == 0 && rx_count == 0, "R8 early start", busy_cyc + rx_count, 0);
    rxrdy_n_i = 1'b0;
    repeat (3) @(negedge clk);

    // R7: zero length
    clr();
    go(0);
    repeat (5) @(negedge clk);
    chk(err_cnt == 1, "R7 err pulse", err_cnt, 1);
    chk(busy_cyc == 0, "R7 no transfer", busy_cyc, 0);

    // R2 R3 R5 R6 vector loop
    for (int v = 0; v < NV; v++) begin
      clr();
      space_mode = VEC[v][1];
      valid_mode = VEC[v][2];
      go(VEC[v][0]);
      wait_done();
      space_mode = 0; valid_mode = 0;
      chk(rx_count == VEC[v][0], "R5 byte count", rx_count, VEC[v][0]);
      chk(done_cnt == 1, "R6 done count", done_cnt, 1);
      chk(wr_n_o == 1'b1 && busy_o == 1'b0, "R6 idle after", {wr_n_o, busy_o}, 2);
      if (VEC[v][3] != 0) begin
        chk(busy_cyc == VEC[v][3], "R5 busy cycles", busy_cyc, VEC[v][3]);
        chk(low_cyc == 7 * VEC[v][0], "R2 strobe low cycles", low_cyc, 7 * VEC[v][0]);
      end
    end

    // R4: freeze inside the strobe-low window
    clr();
    go(1);
    @(negedge clk);
    while (wr_n_o) @(negedge clk);
    space_force = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k == 19) space_force = 1'b0;
      chk(wr_n_o == 1'b0 && done_cnt == 0, "R4 hold", wr_n_o, 0);
    end
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k < 7) chk(wr_n_o == 1'b0, "R4 resume low", wr_n_o, 0);
      else chk(wr_n_o == 1'b1 && done_o == 1'b1, "R4 resume end", {wr_n_o, done_o}, 3);
    end
    repeat (3) @(negedge clk);
    chk(rx_count == 1, "R4 single byte", rx_count, 1);

    // R10: source stall at count 1
    clr();
    valid_hold = 1'b1;
    go(2);
    repeat (40) @(negedge clk);
    chk(rx_count == 0 && wr_n_o == 1'b1, "R10 no write", rx_count, 0);
    chk(src_ready_o == 1'b1 && busy_o == 1'b1, "R10 waiting", {src_ready_o, busy_o}, 3);
    valid_hold = 1'b0;
    wait_done();
    chk(rx_count == 2, "R10 bytes", rx_count, 2);

    // R11: start while busy ignored
    clr();
    go(3);
    repeat (20) @(negedge clk);
    go(5);
    wait_done();
    repeat (100) @(negedge clk);
    chk(rx_count == 3, "R11 bytes", rx_count, 3);
    chk(done_cnt == 1 && busy_cyc == 49, "R11 no restart", busy_cyc, 49);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule